// File: doc/BRIEF.md
# Octal Double-Buffered DAC Code Register Bank

This block is the digital front end of an eight-channel, 13-bit digital-to-analog converter. A shared parallel data bus and a 3-bit channel address feed eight first-stage (input) registers. Each channel also has a second-stage (DAC) register, and the code it holds drives that channel's output code. Writing is governed by an active-low chip select and an active-low write strobe. An active-low load strobe copies all eight input registers into the DAC registers in the same cycle, so several channels can change together.

Both stages are level-sensitive. A stage is "open" while its strobes are low. An open stage copies its source on every rising clock edge, and a closed stage holds its value. If the write and load strobes are open together, bus data reaches the selected channel's output after two clock edges. An active-low clear forces every output code to 0 and raises a clear flag. Clear leaves both register stages untouched, so releasing it brings back the stored codes at once. All strobes are assumed to be synchronous to the clock.

Top module: `dac8_latch_bank`

## Requirements
- R1: While rst_ni is low, every input and DAC register is forced to code 0. After reset, with clr_ni high, all of code_o reads 0 and clr_active_o reads 0.
- R2: Address value n (plain binary, 0 to 7) selects channel n. Channel n's output code sits at code_o[n*13 +: 13].
- R3: While a write is open, every input register other than the addressed one keeps its value.
- R4: While cs_ni and wr_ni are both low, the addressed input register copies data_i on each rising edge. Once either strobe is high, it holds the last value copied.
- R5: While ld_ni is low, every DAC register copies its own input register on each rising edge. All eight channels are updated in the same cycle.
- R6: While ld_ni is high, no DAC register changes, and writes to input registers do not reach code_o.
- R7: With cs_ni, wr_ni and ld_ni all low, data_i applied before edge k appears on the selected channel's code_o after edge k+1.
- R8: While clr_ni is low, all eight codes on code_o read 0 and clr_active_o reads 1. This takes effect in the same cycle, with no clock edge in between.
- R9: Clear alters no register. Writes and loads made while clear is low still take effect. When clr_ni returns high, code_o shows the DAC register contents in the same cycle.
- R10: With only one of cs_ni or wr_ni low, no input register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 13 | Code bus |
| addr_i | input | 3 | Channel select |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low |
| ld_ni | input | 1 | Load strobe for all channels, active low |
| clr_ni | input | 1 | Output clear, active low |
| code_o | output | 104 | Eight 13-bit output codes, channel 0 in the low bits |
| clr_active_o | output | 1 | High while the clear is applied |

## Verification
Two functions can fall in the same cycle. A clear can overlap a write and a load, and a write can overlap a load. The bench asserts clear and then writes one channel and pulses load while clear is still low. It expects zero codes throughout, and expects the newly written value together with every untouched value to appear in the same cycle that clear is released. For the write-and-load overlap, the bench holds all three strobes low. It expects the selected channel's output to keep its old value after the first edge and to show the bus value after the second edge.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int unsigned CH_N   = 8;
  localparam int unsigned CODE_W = 13;
  localparam int unsigned ADDR_W = $clog2(CH_N);
endpackage

// File: rtl/dac_addr_dec.sv
module dac_addr_dec #(
  parameter int unsigned CH_N   = 8,
  parameter int unsigned ADDR_W = $clog2(CH_N)
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CH_N-1:0]   sel_o
);
  for (genvar g = 0; g < CH_N; g++) begin : g_sel
    assign sel_o[g] = en_i && (addr_i == ADDR_W'(g));
  end
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int unsigned CODE_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              ld_en_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] in_q_o,
  output logic [CODE_W-1:0] dac_q_o
);
  logic [CODE_W-1:0] in_q, dac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_q <= '0;
    else if (wr_en_i) in_q <= data_i;
  end

  // second stage samples the pre-edge first stage: one cycle per open stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dac_q <= '0;
    else if (ld_en_i) dac_q <= in_q;
  end

  assign in_q_o  = in_q;
  assign dac_q_o = dac_q;
endmodule

// File: rtl/dac_out_mask.sv
module dac_out_mask #(
  parameter int unsigned CH_N   = 8,
  parameter int unsigned CODE_W = 13
) (
  input  logic                     clr_ni,
  input  logic [CH_N*CODE_W-1:0]   dac_flat_i,
  output logic [CH_N*CODE_W-1:0]   code_o,
  output logic                     clr_active_o
);
  for (genvar g = 0; g < CH_N; g++) begin : g_mask
    assign code_o[g*CODE_W +: CODE_W] = clr_ni ? dac_flat_i[g*CODE_W +: CODE_W] : '0;
  end
  assign clr_active_o = ~clr_ni;
endmodule

// File: rtl/dac8_latch_bank.sv
module dac8_latch_bank
  import dac_bank_pkg::*;
#(
  parameter int unsigned CH_N   = dac_bank_pkg::CH_N,
  parameter int unsigned CODE_W = dac_bank_pkg::CODE_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CODE_W-1:0]        data_i,
  input  logic [$clog2(CH_N)-1:0]  addr_i,
  input  logic                     cs_ni,
  input  logic                     wr_ni,
  input  logic                     ld_ni,
  input  logic                     clr_ni,
  output logic [CH_N*CODE_W-1:0]   code_o,
  output logic                     clr_active_o
);
  localparam int unsigned AW = $clog2(CH_N);

  logic                   wr_open;
  logic                   ld_open;
  logic [CH_N-1:0]        wr_sel;
  logic [CH_N*CODE_W-1:0] in_flat;
  logic [CH_N*CODE_W-1:0] dac_flat;

  assign wr_open = ~cs_ni & ~wr_ni;
  assign ld_open = ~ld_ni;

  dac_addr_dec #(.CH_N(CH_N), .ADDR_W(AW)) u_dec (
    .en_i   (wr_open),
    .addr_i (addr_i),
    .sel_o  (wr_sel)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    dac_chan #(.CODE_W(CODE_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_sel[g]),
      .ld_en_i (ld_open),
      .data_i  (data_i),
      .in_q_o  (in_flat[g*CODE_W +: CODE_W]),
      .dac_q_o (dac_flat[g*CODE_W +: CODE_W])
    );
  end

  dac_out_mask #(.CH_N(CH_N), .CODE_W(CODE_W)) u_mask (
    .clr_ni       (clr_ni),
    .dac_flat_i   (dac_flat),
    .code_o       (code_o),
    .clr_active_o (clr_active_o)
  );
endmodule

// File: rtl/dac8_latch_bank_chk.sv
module dac8_latch_bank_chk #(
  parameter int unsigned CH_N   = 8,
  parameter int unsigned CODE_W = 13
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [CODE_W-1:0]       data_i,
  input logic [$clog2(CH_N)-1:0] addr_i,
  input logic                    cs_ni,
  input logic                    wr_ni,
  input logic                    ld_ni,
  input logic                    clr_ni,
  input logic [CH_N*CODE_W-1:0]  in_flat,
  input logic [CH_N*CODE_W-1:0]  dac_flat,
  input logic [CH_N*CODE_W-1:0]  code_o,
  input logic                    clr_active_o
);
  localparam int unsigned AW = $clog2(CH_N);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else armed <= 1'b1;
  end

  // R8
  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> (code_o == '0) && clr_active_o);

  // R9
  a_r9_clear_shows_dac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni |-> (code_o == dac_flat) && !clr_active_o);

  a_r6_load_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && ld_ni |=> $stable(dac_flat));

  a_r10_partial_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && (cs_ni != wr_ni) |=> $stable(in_flat));

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    a_r3_other_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && !cs_ni && !wr_ni && (addr_i != AW'(g))
      |=> $stable(in_flat[g*CODE_W +: CODE_W]));

    a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && !cs_ni && !wr_ni && (addr_i == AW'(g))
      |=> in_flat[g*CODE_W +: CODE_W] == $past(data_i));

    a_r5_load_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && !ld_ni
      |=> dac_flat[g*CODE_W +: CODE_W] == $past(in_flat[g*CODE_W +: CODE_W]));
  end
endmodule

bind dac8_latch_bank dac8_latch_bank_chk #(.CH_N(CH_N), .CODE_W(CODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .data_i       (data_i),
  .addr_i       (addr_i),
  .cs_ni        (cs_ni),
  .wr_ni        (wr_ni),
  .ld_ni        (ld_ni),
  .clr_ni       (clr_ni),
  .in_flat      (in_flat),
  .dac_flat     (dac_flat),
  .code_o       (code_o),
  .clr_active_o (clr_active_o)
);

// File: tb/sim_dac8_latch_bank.sv
`timescale 1ns/1ps
module sim_dac8_latch_bank;
  localparam int CH = 8;
  localparam int W  = 13;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [W-1:0]    data_i = '0;
  logic [2:0]      addr_i = '0;
  logic            cs_ni = 1'b1, wr_ni = 1'b1, ld_ni = 1'b1, clr_ni = 1'b1;
  logic [CH*W-1:0] code_o;
  logic            clr_active_o;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] exp_q [CH];

  always #2 clk_i = ~clk_i;

  dac8_latch_bank u0 (
    .clk_i, .rst_ni, .data_i, .addr_i, .cs_ni, .wr_ni, .ld_ni, .clr_ni,
    .code_o, .clr_active_o
  );

  function automatic logic [W-1:0] ch_code(int c);
    return code_o[c*W +: W];
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    for (int c = 0; c < CH; c++) chk(req, ch_code(c), exp_q[c]);
  endtask

  task automatic write_ch(int c, logic [W-1:0] d);
    @(negedge clk_i);
    addr_i = 3'(c); data_i = d; cs_ni = 0; wr_ni = 0;
    @(negedge clk_i);
    cs_ni = 1; wr_ni = 1;
  endtask

  task automatic load_all();
    @(negedge clk_i); ld_ni = 0;
    @(negedge clk_i); ld_ni = 1;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    for (int c = 0; c < CH; c++) exp_q[c] = '0;
    chk_all("R1");
    chk("R1", W'(clr_active_o), '0);
  endtask

  task automatic t_addr_isolation();
    for (int c = 0; c < CH; c++) write_ch(c, W'(1000 * (c + 1) + c));
    @(negedge clk_i);
    chk_all("R6");  // nothing loaded yet
    load_all();
    for (int c = 0; c < CH; c++) exp_q[c] = W'(1000 * (c + 1) + c);
    chk_all("R2");
    chk("R5", ch_code(7), 13'd8007);
  endtask

  task automatic t_partial();
    @(negedge clk_i);
    addr_i = 3'd3; data_i = 13'd77; cs_ni = 0; wr_ni = 1;
    @(negedge clk_i);
    cs_ni = 1; wr_ni = 0;
    @(negedge clk_i);
    wr_ni = 1;
    load_all();
    chk_all("R10");
  endtask

  task automatic t_hold();
    @(negedge clk_i);
    addr_i = 3'd4; cs_ni = 0; wr_ni = 0; data_i = 13'd11;
    @(negedge clk_i); data_i = 13'd22;
    @(negedge clk_i); data_i = 13'd8191;
    @(negedge clk_i); wr_ni = 1; data_i = 13'd5;
    @(negedge clk_i); cs_ni = 1;
    load_all();
    exp_q[4] = 13'd8191;
    chk_all("R4");
    chk_all("R3");
  endtask

  task automatic t_load_hold();
    write_ch(0, 13'd4321);
    @(negedge clk_i);
    chk("R6", ch_code(0), exp_q[0]);
    load_all();
    exp_q[0] = 13'd4321;
    chk("R5", ch_code(0), 13'd4321);
  endtask

  task automatic t_pass();
    @(negedge clk_i);
    addr_i = 3'd6; data_i = 13'd1234; cs_ni = 0; wr_ni = 0; ld_ni = 0;
    @(negedge clk_i);
    chk("R7", ch_code(6), exp_q[6]);  // one edge: only first stage moved
    @(negedge clk_i);
    exp_q[6] = 13'd1234;
    chk("R7", ch_code(6), 13'd1234);
    cs_ni = 1; wr_ni = 1; ld_ni = 1;
    chk_all("R7");
  endtask

  task automatic t_clear();
    @(negedge clk_i);
    clr_ni = 0;
    #0.1;
    for (int c = 0; c < CH; c++) chk("R8", ch_code(c), '0);
    chk("R8", W'(clr_active_o), 13'd1);
    write_ch(5, 13'd999);
    load_all();
    exp_q[5] = 13'd999;
    chk("R8", ch_code(5), '0);
    @(negedge clk_i);
    clr_ni = 1;
    #0.1;
    chk_all("R9");
    chk("R9", W'(clr_active_o), '0);
  endtask

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_addr_isolation();
    t_partial();
    t_hold();
    t_load_hold();
    t_pass();
    t_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule